// File: doc/BRIEF.md
# TDC readout word decoder

This block sits behind the bus that drains a free-running multi-channel time-to-digital converter. It takes one 32-bit readout word per accepted cycle and sorts it into a header or a hit. A header carries a coarse 9-bit trigger time. The block stores that time and rescales it into hit-count units. A hit carries a channel field and a 16-bit time count. Hits that hold the overflow marker are dropped. When a hit count is smaller than the stored trigger time, the free-running counter wrapped between the hit and the trigger, and the programmed maximum count is added back.

Every accepted word that is not an overflow marker produces one record, one cycle later. The record holds the slot, the error flags, a 1-based channel number, a 17-bit time and a flag that says whether the roll-over correction could be applied. Header records let downstream logic see the trigger time itself. In high-resolution mode, adjacent channel pairs report as a single channel.

Top module: `tdc_word_decoder`

## Requirements
- R1: While `rst_ni` is low, `rec_valid_o` and `word_ready_o` are 0. From the first clock edge after reset is released, `word_ready_o` is 1.
- R2: Bit 23 of a word selects its type: 0 is a header and 1 is a hit. A header gives a record with `rec_is_hdr_o`=1, `rec_trig_ok_o`=1, `rec_chan_o` = bits 5..0 + 1 and `rec_time_o` = bits 15..7 × 128 + 127.
- R3: Every record copies the slot from word bits 31..27 to `rec_slot_o` and the error flags from bits 26..24 to `rec_err_o`.
- R4: For a hit, the count is bits 15..0. The channel is the 6-bit field that starts at bit `chan_offset_i`, and `rec_chan_o` reports that field + 1.
- R5: A hit whose count is 65535 is an overflow marker. It produces no record.
- R6: Once a header has been seen, a hit whose count is below the stored rescaled trigger time reports count + `window_max_i`. Any other hit reports the count unchanged. `rec_trig_ok_o` is 1 in both cases.
- R7: A hit that arrives before any header since reset has `rec_trig_ok_o`=0 and reports its raw count with no correction.
- R8: With `hires_i`=1, the reported channel is field/2 + 1 for both word types (the pair form of (channel−1)/2+1).
- R9: A word accepted at a clock edge gives a record that is valid for exactly the following cycle. A cycle with no accepted word leaves `rec_valid_o` at 0.
- R10: A hit count equal to the stored rescaled trigger time is not corrected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | Input word is present |
| word_ready_o | output | 1 | Block accepts a word |
| word_data_i | input | 32 | Readout word |
| chan_offset_i | input | 5 | Bit position of the channel field in hit words |
| hires_i | input | 1 | High-resolution mode: channels combine in pairs |
| window_max_i | input | 16 | Maximum count before wrap, added on roll-over |
| rec_valid_o | output | 1 | Record strobe |
| rec_is_hdr_o | output | 1 | Record comes from a header word |
| rec_slot_o | output | 5 | Slot number |
| rec_err_o | output | 3 | Error flags |
| rec_chan_o | output | 7 | 1-based channel number |
| rec_time_o | output | 17 | Corrected time, or rescaled trigger time for headers |
| rec_trig_ok_o | output | 1 | A header was seen, so the roll-over check applied |

## Verification
The hit stream is driven in several orders. It starts with hits before any header. It then mixes counts above, equal to, and below a small trigger time, and repeats this against the largest possible trigger time. This separates a missing comparison, a wrong compare direction, and an off-by-one at equality. Slot and flag values at both extremes show whether any field boundary is misplaced. The same channel fields are sent in both resolution modes and at two channel offsets, so pairing and field position are tested separately. Overflow markers are placed between valid hits, and a mid-run reset is applied, to show that suppression and loss of the trigger state both act locally.

// File: rtl/tdc_dec_pkg.sv
package tdc_dec_pkg;
  localparam int unsigned WORD_W_DEF  = 32;
  localparam int unsigned CNT_W_DEF   = 16;
  localparam int unsigned TRIG_W_DEF  = 9;
  localparam int unsigned TRIG_SH_DEF = 7;
  localparam int unsigned CHAN_W_DEF  = 6;
  localparam int unsigned KIND_BIT    = 23;
  localparam int unsigned SLOT_W      = 5;
  localparam int unsigned ERR_W       = 3;

  typedef enum logic {
    KIND_HDR = 1'b0,
    KIND_HIT = 1'b1
  } word_kind_e;
endpackage

// File: rtl/tdc_field_split.sv
module tdc_field_split
  import tdc_dec_pkg::*;
#(
  parameter int unsigned WORD_W  = WORD_W_DEF,
  parameter int unsigned CNT_W   = CNT_W_DEF,
  parameter int unsigned TRIG_W  = TRIG_W_DEF,
  parameter int unsigned TRIG_SH = TRIG_SH_DEF,
  parameter int unsigned CHAN_W  = CHAN_W_DEF,
  localparam int unsigned OFF_W  = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [OFF_W-1:0]  chan_offset_i,
  input  logic              hires_i,
  output word_kind_e        kind_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [ERR_W-1:0]  err_o,
  output logic [TRIG_W-1:0] trig_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CHAN_W:0]   chan_o
);
  logic [WORD_W-1:0] shifted;
  logic [CHAN_W-1:0] field;
  logic [CHAN_W:0]   field_x;

  assign kind_o  = word_kind_e'(word_i[KIND_BIT]);
  assign slot_o  = word_i[WORD_W-1 -: SLOT_W];
  assign err_o   = word_i[WORD_W-1-SLOT_W -: ERR_W];
  assign trig_o  = word_i[TRIG_SH +: TRIG_W];
  assign cnt_o   = word_i[CNT_W-1:0];
  assign shifted = word_i >> chan_offset_i;

  always_comb begin
    if (kind_o == KIND_HIT) field = shifted[CHAN_W-1:0];
    else                    field = word_i[CHAN_W-1:0];
  end

  assign field_x = {1'b0, field};
  // numbering starts at 1; pair mode folds two channels into one
  assign chan_o  = hires_i ? (field_x >> 1) + 1'b1 : field_x + 1'b1;
endmodule

// File: rtl/tdc_trig_hold.sv
module tdc_trig_hold #(
  parameter int unsigned TRIG_W  = tdc_dec_pkg::TRIG_W_DEF,
  parameter int unsigned TRIG_SH = tdc_dec_pkg::TRIG_SH_DEF,
  localparam int unsigned SC_W   = TRIG_W + TRIG_SH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TRIG_W-1:0] trig_i,
  output logic [SC_W-1:0]   scaled_o,
  output logic [SC_W-1:0]   trig_q_o,
  output logic              seen_o
);
  logic [SC_W-1:0] trig_q;
  logic            seen_q;

  // x*2^SH + (2^SH-1): coarse tick covers the top of its fine range
  assign scaled_o = {trig_i, {TRIG_SH{1'b1}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= '0;
      seen_q <= 1'b0;
    end else if (load_i) begin
      trig_q <= scaled_o;
      seen_q <= 1'b1;
    end
  end

  assign trig_q_o = trig_q;
  assign seen_o   = seen_q;
endmodule

// File: rtl/tdc_rollover_fix.sv
module tdc_rollover_fix #(
  parameter int unsigned CNT_W  = tdc_dec_pkg::CNT_W_DEF,
  parameter int unsigned SC_W   = tdc_dec_pkg::CNT_W_DEF,
  localparam int unsigned TIME_W = CNT_W + 1,
  localparam int unsigned CMP_W  = (SC_W > CNT_W) ? SC_W : CNT_W
) (
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [SC_W-1:0]   trig_i,
  input  logic              seen_i,
  input  logic [CNT_W-1:0]  window_i,
  output logic [TIME_W-1:0] time_o
);
  logic [CMP_W-1:0] cnt_c, trig_c;
  logic             wrap;

  assign cnt_c  = CMP_W'(cnt_i);
  assign trig_c = CMP_W'(trig_i);
  assign wrap   = seen_i && (cnt_c < trig_c);

  always_comb begin
    if (wrap) time_o = {1'b0, cnt_i} + {1'b0, window_i};
    else      time_o = {1'b0, cnt_i};
  end
endmodule

// File: rtl/tdc_word_decoder.sv
module tdc_word_decoder
  import tdc_dec_pkg::*;
#(
  parameter int unsigned WORD_W  = WORD_W_DEF,
  parameter int unsigned CNT_W   = CNT_W_DEF,
  parameter int unsigned TRIG_W  = TRIG_W_DEF,
  parameter int unsigned TRIG_SH = TRIG_SH_DEF,
  parameter int unsigned CHAN_W  = CHAN_W_DEF,
  localparam int unsigned OFF_W  = $clog2(WORD_W),
  localparam int unsigned TIME_W = CNT_W + 1,
  localparam int unsigned SC_W   = TRIG_W + TRIG_SH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  input  logic [WORD_W-1:0] word_data_i,
  input  logic [OFF_W-1:0]  chan_offset_i,
  input  logic              hires_i,
  input  logic [CNT_W-1:0]  window_max_i,
  output logic              rec_valid_o,
  output logic              rec_is_hdr_o,
  output logic [SLOT_W-1:0] rec_slot_o,
  output logic [ERR_W-1:0]  rec_err_o,
  output logic [CHAN_W:0]   rec_chan_o,
  output logic [TIME_W-1:0] rec_time_o,
  output logic              rec_trig_ok_o
);
  word_kind_e        kind;
  logic [SLOT_W-1:0] slot;
  logic [ERR_W-1:0]  err;
  logic [TRIG_W-1:0] trig_raw;
  logic [CNT_W-1:0]  cnt;
  logic [CHAN_W:0]   chan;
  logic [SC_W-1:0]   trig_now, trig_held;
  logic              seen;
  logic [TIME_W-1:0] hit_time, rec_time_d;
  logic              ready_q, accept, is_ovf, emit;

  tdc_field_split #(
    .WORD_W(WORD_W), .CNT_W(CNT_W), .TRIG_W(TRIG_W),
    .TRIG_SH(TRIG_SH), .CHAN_W(CHAN_W)
  ) u_split (
    .word_i(word_data_i), .chan_offset_i(chan_offset_i), .hires_i(hires_i),
    .kind_o(kind), .slot_o(slot), .err_o(err), .trig_o(trig_raw),
    .cnt_o(cnt), .chan_o(chan)
  );

  assign accept = word_valid_i && ready_q;
  assign is_ovf = (kind == KIND_HIT) && (&cnt);
  assign emit   = accept && !is_ovf;

  tdc_trig_hold #(.TRIG_W(TRIG_W), .TRIG_SH(TRIG_SH)) u_trig (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(accept && (kind == KIND_HDR)), .trig_i(trig_raw),
    .scaled_o(trig_now), .trig_q_o(trig_held), .seen_o(seen)
  );

  tdc_rollover_fix #(.CNT_W(CNT_W), .SC_W(SC_W)) u_fix (
    .cnt_i(cnt), .trig_i(trig_held), .seen_i(seen),
    .window_i(window_max_i), .time_o(hit_time)
  );

  always_comb begin
    if (kind == KIND_HDR) rec_time_d = TIME_W'(trig_now);
    else                  rec_time_d = hit_time;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q       <= 1'b0;
      rec_valid_o   <= 1'b0;
      rec_is_hdr_o  <= 1'b0;
      rec_slot_o    <= '0;
      rec_err_o     <= '0;
      rec_chan_o    <= '0;
      rec_time_o    <= '0;
      rec_trig_ok_o <= 1'b0;
    end else begin
      ready_q     <= 1'b1;
      rec_valid_o <= emit;
      if (emit) begin
        rec_is_hdr_o  <= (kind == KIND_HDR);
        rec_slot_o    <= slot;
        rec_err_o     <= err;
        rec_chan_o    <= chan;
        rec_time_o    <= rec_time_d;
        rec_trig_ok_o <= (kind == KIND_HDR) || seen;
      end
    end
  end

  assign word_ready_o = ready_q;
endmodule

// File: rtl/tdc_word_decoder_chk.sv
module tdc_word_decoder_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned CHAN_W = 6,
  parameter int unsigned TRIG_SH = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              word_valid_i,
  input logic              word_ready_o,
  input logic [WORD_W-1:0] word_data_i,
  input logic              rec_valid_o,
  input logic              rec_is_hdr_o,
  input logic [4:0]        rec_slot_o,
  input logic [CHAN_W:0]   rec_chan_o,
  input logic [CNT_W:0]    rec_time_o,
  input logic              rec_trig_ok_o
);
  logic acc, ovf;
  assign acc = word_valid_i && word_ready_o;
  assign ovf = word_data_i[23] && (&word_data_i[CNT_W-1:0]);

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && ovf |=> !rec_valid_o);
  // R9
  rec_on_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !ovf |=> rec_valid_o);
  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !rec_valid_o);
  // R3
  slot_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !ovf |=> rec_slot_o == $past(word_data_i[WORD_W-1 -: 5]));
  // R4
  chan_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> rec_chan_o != '0);
  // R2
  hdr_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_is_hdr_o |-> (&rec_time_o[TRIG_SH-1:0]) && rec_trig_ok_o);
  // R7
  raw_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_trig_ok_o |-> !rec_time_o[CNT_W] && !rec_is_hdr_o);
endmodule

bind tdc_word_decoder tdc_word_decoder_chk #(
  .WORD_W(WORD_W), .CNT_W(CNT_W), .CHAN_W(CHAN_W), .TRIG_SH(TRIG_SH)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .word_valid_i(word_valid_i),
  .word_ready_o(word_ready_o), .word_data_i(word_data_i),
  .rec_valid_o(rec_valid_o), .rec_is_hdr_o(rec_is_hdr_o),
  .rec_slot_o(rec_slot_o), .rec_chan_o(rec_chan_o),
  .rec_time_o(rec_time_o), .rec_trig_ok_o(rec_trig_ok_o)
);

// File: tb/tdc_word_decoder_bench.sv
module tdc_word_decoder_bench;
  localparam int unsigned WIN = 16'hFFC0;

  typedef struct packed {
    logic        is_hdr;
    logic [4:0]  slot;
    logic [2:0]  err;
    logic [8:0]  trig;
    logic [5:0]  chan;
    logic [15:0] cnt;
    logic        hires;
    logic        exp_v;
    logic [6:0]  exp_chan;
    logic [16:0] exp_time;
    logic        exp_ok;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 5'd3,  3'd0, 9'd0,   6'd5,  16'd100,   1'b0, 1'b1, 7'd6,  17'd100,    1'b0}, // R7
    '{1'b1, 5'd3,  3'd0, 9'd10,  6'd2,  16'd0,     1'b0, 1'b1, 7'd3,  17'd1407,   1'b1}, // R2
    '{1'b0, 5'd3,  3'd0, 9'd0,   6'd0,  16'd2000,  1'b0, 1'b1, 7'd1,  17'd2000,   1'b1}, // R6
    '{1'b0, 5'd3,  3'd0, 9'd0,   6'd63, 16'd500,   1'b0, 1'b1, 7'd64, 17'd65972,  1'b1}, // R6
    '{1'b0, 5'd3,  3'd0, 9'd0,   6'd7,  16'd1407,  1'b0, 1'b1, 7'd8,  17'd1407,   1'b1}, // R10
    '{1'b0, 5'd3,  3'd0, 9'd0,   6'd7,  16'd65535, 1'b0, 1'b0, 7'd0,  17'd0,      1'b0}, // R5
    '{1'b0, 5'd31, 3'd7, 9'd0,   6'd9,  16'd1406,  1'b0, 1'b1, 7'd10, 17'd66878,  1'b1}, // R3
    '{1'b0, 5'd0,  3'd5, 9'd0,   6'd9,  16'd3000,  1'b1, 1'b1, 7'd5,  17'd3000,   1'b1}, // R8
    '{1'b1, 5'd16, 3'd2, 9'd511, 6'd4,  16'd0,     1'b1, 1'b1, 7'd3,  17'd65535,  1'b1}, // R8 R2
    '{1'b0, 5'd16, 3'd2, 9'd0,   6'd0,  16'd65534, 1'b0, 1'b1, 7'd1,  17'd131006, 1'b1}, // R6
    '{1'b0, 5'd16, 3'd2, 9'd0,   6'd0,  16'd65535, 1'b0, 1'b0, 7'd0,  17'd0,      1'b0}, // R5
    '{1'b1, 5'd1,  3'd1, 9'd0,   6'd0,  16'd0,     1'b0, 1'b1, 7'd1,  17'd127,    1'b1}, // R2
    '{1'b0, 5'd1,  3'd1, 9'd0,   6'd2,  16'd127,   1'b0, 1'b1, 7'd3,  17'd127,    1'b1}, // R10
    '{1'b0, 5'd1,  3'd1, 9'd0,   6'd2,  16'd126,   1'b0, 1'b1, 7'd3,  17'd65598,  1'b1}  // R6
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        word_valid_i = 1'b0;
  logic        word_ready_o;
  logic [31:0] word_data_i = '0;
  logic [4:0]  chan_offset_i = 5'd16;
  logic        hires_i = 1'b0;
  logic [15:0] window_max_i = WIN[15:0];
  logic        rec_valid_o, rec_is_hdr_o, rec_trig_ok_o;
  logic [4:0]  rec_slot_o;
  logic [2:0]  rec_err_o;
  logic [6:0]  rec_chan_o;
  logic [16:0] rec_time_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  tdc_word_decoder u_tdc_word_decoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_valid_i(word_valid_i),
    .word_ready_o(word_ready_o), .word_data_i(word_data_i),
    .chan_offset_i(chan_offset_i), .hires_i(hires_i), .window_max_i(window_max_i),
    .rec_valid_o(rec_valid_o), .rec_is_hdr_o(rec_is_hdr_o), .rec_slot_o(rec_slot_o),
    .rec_err_o(rec_err_o), .rec_chan_o(rec_chan_o), .rec_time_o(rec_time_o),
    .rec_trig_ok_o(rec_trig_ok_o)
  );

  function automatic logic [31:0] mk_word(vec_t v, int off);
    if (v.is_hdr) return {v.slot, v.err, 1'b0, 7'd0, v.trig, 1'b0, v.chan};
    return {v.slot, v.err, 1'b1, 23'd0} | (32'(v.chan) << off) | 32'(v.cnt);
  endfunction

  task automatic check(string req, logic ok, string act, string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %s expected %s", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic send(logic [31:0] w);
    @(negedge clk_i);
    word_valid_i = 1'b1;
    word_data_i  = w;
    @(posedge clk_i);
    #1;
  endtask

  task automatic check_rec(string req, logic ev, logic eh, logic [4:0] es, logic [2:0] ee,
                           logic [6:0] ec, logic [16:0] et, logic eo);
    if (!ev) begin
      check(req, rec_valid_o == 1'b0, $sformatf("valid=%0b", rec_valid_o), "valid=0");
    end else begin
      check(req, rec_valid_o && rec_is_hdr_o == eh && rec_slot_o == es && rec_err_o == ee &&
                 rec_chan_o == ec && rec_time_o == et && rec_trig_ok_o == eo,
            $sformatf("v=%0b h=%0b s=%0d e=%0d c=%0d t=%0d ok=%0b", rec_valid_o, rec_is_hdr_o,
                      rec_slot_o, rec_err_o, rec_chan_o, rec_time_o, rec_trig_ok_o),
            $sformatf("v=1 h=%0b s=%0d e=%0d c=%0d t=%0d ok=%0b", eh, es, ee, ec, et, eo));
    end
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    vec_t v;
    // R1: reset state
    #10;
    check("R1", rec_valid_o == 1'b0 && word_ready_o == 1'b0,
          $sformatf("v=%0b r=%0b", rec_valid_o, word_ready_o), "v=0 r=0");
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    check("R1", word_ready_o == 1'b1, $sformatf("r=%0b", word_ready_o), "r=1");

    for (int i = 0; i < NV; i++) begin
      hires_i = VEC[i].hires;
      send(mk_word(VEC[i], 16));
      check_rec($sformatf("vec%0d", i), VEC[i].exp_v, VEC[i].is_hdr, VEC[i].slot,
                VEC[i].err, VEC[i].exp_chan, VEC[i].exp_time, VEC[i].exp_ok);
    end

    // R9: idle cycle drops the strobe
    @(negedge clk_i) word_valid_i = 1'b0;
    hires_i = 1'b0;
    @(posedge clk_i);
    #1;
    check_rec("R9", 1'b0, 1'b0, 5'd0, 3'd0, 7'd0, 17'd0, 1'b0);

    // R4: channel field at offset 8, bits 13..8 = 0x2A; trigger 127 held
    chan_offset_i = 5'd8;
    send({5'd2, 3'd0, 1'b1, 7'd0, 16'h2A00});
    check_rec("R4", 1'b1, 1'b0, 5'd2, 3'd0, 7'd43, 17'd10752, 1'b1);
    // R8: same field in pair mode
    hires_i = 1'b1;
    send({5'd2, 3'd0, 1'b1, 7'd0, 16'h2A00});
    check_rec("R8", 1'b1, 1'b0, 5'd2, 3'd0, 7'd22, 17'd10752, 1'b1);
    hires_i = 1'b0;
    chan_offset_i = 5'd16;

    // R1 R7: reset mid-run forgets the trigger
    @(negedge clk_i) begin
      word_valid_i = 1'b0;
      rst_ni = 1'b0;
    end
    #1;
    check("R1", rec_valid_o == 1'b0, $sformatf("v=%0b", rec_valid_o), "v=0");
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i);
    v = VEC[0];
    v.cnt = 16'd50;
    send(mk_word(v, 16));
    check_rec("R7", 1'b1, 1'b0, 5'd3, 3'd0, 7'd6, 17'd50, 1'b0);
    // R9: record lasts one cycle only
    @(negedge clk_i) word_valid_i = 1'b0;
    @(posedge clk_i);
    #1;
    check_rec("R9", 1'b0, 1'b0, 5'd0, 3'd0, 7'd0, 17'd0, 1'b0);

    finish_run();
  end
endmodule